// File: doc/BRIEF.md
# Byte-Level I2C Bus Master with Register Bank

This block is an I2C bus master that software drives one byte at a time through a small bank of 8-bit registers. Software places a byte in the data register and then writes a command word to the status register: a master mode with the start bit set while the bus is idle produces a START condition, and the data register goes out as the address byte. Each later byte is sent or received according to the selected master mode, transmit or receive.

At the end of every byte, including its acknowledge bit, the controller holds SCL low and raises a pending flag. If interrupts are enabled the flag also appears on the interrupt output. Software moves the transfer forward by writing the pending flag to 0. To end a transfer, software writes the status register with the start bit at 0 while the bus is busy, then clears the pending flag. In receive mode, software clears the acknowledge-enable bit before the last byte so that this byte gets a NACK.

Both bus lines are open-drain. An output of 1 pulls the line low, and an output of 0 lets it float high. The own-address register, the line-control register and the slave and arbitration status flags are storage or constant stubs only.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset every register reads 0x00, `irq` is 0 and neither line is pulled low.
- R2: A status write (offset 0x04) starts a transfer only when all of the following hold: the bus is idle, bit 7 is 1 (master mode), bit 4 is 1 (output enable) and bit 5 is 1. The transfer begins with a START (SDA falls while SCL is high), status bit 5 then reads 1 (busy), and the data register is sent MSB first as the first byte. In every other case the write starts nothing.
- R3: The SCL period is P*(D+1) clock cycles, with equal low and high halves. P is 16 when control bit 6 is 0 and 512 when it is 1. D is control bits 3:0.
- R4: After the ninth SCL pulse of each byte, control bit 4 (pending) becomes 1 and SCL is held low. Both stay that way until software writes the control register (offset 0x00) with bit 4 at 0. Writing bit 4 as 1 changes nothing.
- R5: `irq` is high exactly when pending is 1 and control bit 5 is 1.
- R6: In status mode 11 (master transmit), each released byte sends the data register MSB first. The ninth bit is sampled into status bit 0, where 0 means ACK.
- R7: In status mode 10 (master receive), the master leaves SDA free for eight bits and shifts them in MSB first. The received byte appears in the data register (offset 0x0C) in the same cycle that pending sets. Before that, the data register reads its previous contents.
- R8: In master receive, the master drives the ninth bit low (ACK) if control bit 7 was 1 when the byte was released. Otherwise it leaves the ninth bit free (NACK).
- R9: A status write with bit 5 at 0 while busy arms a STOP. The STOP runs when pending is next cleared: SCL is released, then SDA rises while SCL is high. Busy clears only at that point, and no further byte is clocked.
- R10: While a transfer is in progress, SDA changes only while SCL is low, except for the START and STOP edges.
- R11: The own-address register (offset 0x08) stores all 8 bits. The line-control register (offset 0x10) stores bits 2:0 and reads 0 above them. Status bits 3:1 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, 0 when no read strobe |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench uses an open-drain bus model with an attached target. Transmit bytes are tried with both an acknowledging and a non-acknowledging target, which separates the sampled ACK level from the byte contents. Receive bytes are tried with complementary bit patterns (0x3C and 0xC3) under both ACK settings, which catches reversed bit order and a wrong ninth-bit drive. Three clock settings (fast source with divider 0 and 2, and the slow source) separate the divider from the source select. Command writes that must be ignored are checked against bus activity and the busy bit: slave mode, output disabled, start while busy, and pending written as 1.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_CTRL = 5'h00;
    localparam logic [REG_AW-1:0] OFS_STAT = 5'h04;
    localparam logic [REG_AW-1:0] OFS_OWN  = 5'h08;
    localparam logic [REG_AW-1:0] OFS_DATA = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_LINE = 5'h10;

    localparam logic [1:0] MODE_MRX = 2'b10;
    localparam logic [1:0] MODE_MTX = 2'b11;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_LOW, S_HIGH, S_HOLD, S_STOP_LO, S_STOP_HI
    } eng_state_e;

    // control register image, bit 7 down to bit 0
    typedef struct packed {
        logic       ack_en;
        logic       slow_clk;
        logic       irq_en;
        logic       pend;
        logic [3:0] div;
    } ctrl_t;

    typedef struct packed {
        logic [1:0] mode;
        logic       txen;
    } stat_t;

    typedef struct packed {
        logic [7:0] rx_byte;
        logic       ack_bit;
        logic       was_rx;
    } done_t;

    function automatic logic [2:0] msb_first(input logic [3:0] idx);
        return 3'd7 - idx[2:0];
    endfunction

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int PRE_FAST = 16,
    parameter int PRE_SLOW = 512,
    parameter int DIV_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             slow,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = $clog2((PRE_SLOW / 2) * (2 ** DIV_W)) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;

    always_comb begin
        if (slow)
            half = CNT_W'((PRE_SLOW / 2) * (int'(div) + 1));
        else
            half = CNT_W'((PRE_FAST / 2) * (int'(div) + 1));
        tick = !clr && (cnt == half - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start_cmd,
    input  logic       release_i,
    input  logic       stop_req,
    input  logic [1:0] mode,
    input  logic       ack_en,
    input  logic [7:0] data_reg,
    input  logic       sda_in,
    output logic       tick_clr,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       done,
    output done_t      done_info
);
    eng_state_e state;
    logic [3:0] bit_idx;
    logic       is_rx;
    logic       ack_drv;
    logic [7:0] tx_byte;
    logic [7:0] rx_sh;

    always_comb begin
        busy     = (state != S_IDLE);
        tick_clr = (state == S_IDLE) || (state == S_HOLD);
        scl_oe   = (state == S_LOW) || (state == S_HOLD) || (state == S_STOP_LO);
        unique case (state)
            S_START, S_STOP_LO, S_STOP_HI: sda_oe = 1'b1;
            S_LOW, S_HIGH:
                sda_oe = bit_idx[3] ? (is_rx && ack_drv)
                                    : (!is_rx && !tx_byte[msb_first(bit_idx)]);
            default: sda_oe = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            bit_idx   <= '0;
            is_rx     <= 1'b0;
            ack_drv   <= 1'b0;
            tx_byte   <= '0;
            rx_sh     <= '0;
            done      <= 1'b0;
            done_info <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: if (start_cmd) begin
                    tx_byte <= data_reg;
                    is_rx   <= 1'b0;
                    bit_idx <= '0;
                    state   <= S_START;
                end
                S_START: if (tick) state <= S_LOW;
                S_LOW:   if (tick) state <= S_HIGH;
                S_HIGH: if (tick) begin
                    if (!bit_idx[3]) begin
                        rx_sh   <= {rx_sh[6:0], sda_in};
                        bit_idx <= bit_idx + 1'b1;
                        state   <= S_LOW;
                    end else begin
                        done      <= 1'b1;
                        done_info <= '{rx_byte: rx_sh, ack_bit: sda_in, was_rx: is_rx};
                        state     <= S_HOLD;
                    end
                end
                S_HOLD: if (release_i) begin
                    if (stop_req) begin
                        state <= S_STOP_LO;
                    end else begin
                        tx_byte <= data_reg;
                        is_rx   <= (mode != MODE_MTX);
                        ack_drv <= ack_en;
                        bit_idx <= '0;
                        state   <= S_LOW;
                    end
                end
                S_STOP_LO: if (tick) state <= S_STOP_HI;
                S_STOP_HI: if (tick) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              busy,
    input  logic              done,
    input  done_t             done_info,
    output ctrl_t             ctrl,
    output logic [1:0]        mode,
    output logic [7:0]        data_reg,
    output logic              start_cmd,
    output logic              release_o,
    output logic              stop_req
);
    stat_t      stat_q;
    logic [7:0] own_q;
    logic [2:0] line_q;
    logic       lastack_q;

    logic wr_ctrl, wr_stat;

    always_comb begin
        wr_ctrl   = wr_en && (addr == OFS_CTRL);
        wr_stat   = wr_en && (addr == OFS_STAT);
        start_cmd = wr_stat && wdata[7] && wdata[5] && wdata[4] && !busy;
        release_o = wr_ctrl && !wdata[4] && ctrl.pend;
        mode      = stat_q.mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            stat_q    <= '0;
            own_q     <= '0;
            data_reg  <= '0;
            line_q    <= '0;
            lastack_q <= 1'b0;
            stop_req  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl.ack_en   <= wdata[7];
                ctrl.slow_clk <= wdata[6];
                ctrl.irq_en   <= wdata[5];
                ctrl.div      <= wdata[3:0];
                if (!wdata[4]) ctrl.pend <= 1'b0;
            end
            if (wr_stat) stat_q <= '{mode: wdata[7:6], txen: wdata[4]};
            if (wr_en && addr == OFS_OWN)  own_q    <= wdata;
            if (wr_en && addr == OFS_DATA) data_reg <= wdata;
            if (wr_en && addr == OFS_LINE) line_q   <= wdata[2:0];
            if (done) begin
                ctrl.pend <= 1'b1;
                lastack_q <= done_info.ack_bit;
                if (done_info.was_rx) data_reg <= done_info.rx_byte;
            end
            if (!busy)
                stop_req <= 1'b0;
            else if (wr_stat && !wdata[5])
                stop_req <= 1'b1;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (rd_en) begin
            unique case (addr)
                OFS_CTRL: rdata = ctrl;
                OFS_STAT: rdata = {stat_q.mode, busy, stat_q.txen, 3'b000, lastack_q};
                OFS_OWN:  rdata = own_q;
                OFS_DATA: rdata = data_reg;
                OFS_LINE: rdata = {5'b00000, line_q};
                default:  rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
    import i2cm_pkg::*;
#(
    parameter int PRE_FAST = 16,
    parameter int PRE_SLOW = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic              scl_oe,
    input  logic              sda_in,
    output logic              sda_oe
);
    ctrl_t      ctrl;
    logic [1:0] mode;
    logic [7:0] data_reg;
    logic       start_cmd, release_p, stop_req;
    logic       busy, done, tick, tick_clr;
    logic       pend;
    done_t      done_info;

    assign pend = ctrl.pend;
    assign irq  = ctrl.pend && ctrl.irq_en;

    i2cm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .rd_en     (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .busy      (busy),
        .done      (done),
        .done_info (done_info),
        .ctrl      (ctrl),
        .mode      (mode),
        .data_reg  (data_reg),
        .start_cmd (start_cmd),
        .release_o (release_p),
        .stop_req  (stop_req)
    );

    i2cm_tick #(
        .PRE_FAST (PRE_FAST),
        .PRE_SLOW (PRE_SLOW),
        .DIV_W    (4)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (tick_clr),
        .slow (ctrl.slow_clk),
        .div  (ctrl.div),
        .tick (tick)
    );

    i2cm_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .start_cmd (start_cmd),
        .release_i (release_p),
        .stop_req  (stop_req),
        .mode      (mode),
        .ack_en    (ctrl.ack_en),
        .data_reg  (data_reg),
        .sda_in    (sda_in),
        .tick_clr  (tick_clr),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .busy      (busy),
        .done      (done),
        .done_info (done_info)
    );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
    import i2cm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              irq,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              pend,
    input logic              busy
);
    p_start_shape_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!scl_oe && sda_oe));

    p_start_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(reg_wr && reg_addr == OFS_STAT && reg_wdata[5]));

    p_hold_low_r4: assert property (@(posedge clk) disable iff (rst)
        pend |-> scl_oe);

    p_clear_by_sw_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> $past(reg_wr && reg_addr == OFS_CTRL && !reg_wdata[4]));

    p_irq_pend_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> pend);

    p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!scl_oe && !sda_oe));

    p_sda_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && $past(!scl_oe) && busy && $past(busy)) |-> (sda_oe == $past(sda_oe)));
endmodule

bind i2c_reg_master i2cm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .pend      (pend),
    .busy      (busy)
);

// File: tb/test_i2c_reg_master.sv
`timescale 1ns/1ps
module test_i2c_reg_master;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe, sda_in;

    always #4 clk = ~clk;

    i2c_reg_master i_i2c_reg_master (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_oe(scl_oe), .sda_in(sda_in), .sda_oe(sda_oe)
    );

    // open-drain bus with a simple target
    logic       slave_tx = 1'b0, slave_ack = 1'b1;
    logic [7:0] slave_byte = 8'h00;
    int         nb = 0;
    logic       slave_pull, scl_line, sda_line;
    assign slave_pull = slave_tx ? (nb < 8 && !slave_byte[7 - nb]) : (nb == 8 && slave_ack);
    assign scl_line   = !scl_oe;
    assign sda_line   = !(sda_oe || slave_pull);
    assign sda_in     = sda_line;

    int   cyc = 0, rises = 0, last_rise = 0, period = 0;
    int   n_start = 0, n_stop = 0, n_cap = 0;
    logic [7:0] cur = '0, cap_byte = '0;
    logic cap_ack = 1'b0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (prev_scl && scl_line && prev_sda && !sda_line) begin
                n_start++; rises = 0; nb = 0;
            end
            if (prev_scl && scl_line && !prev_sda && sda_line) n_stop++;
            if (!prev_scl && scl_line) begin
                if (rises % 9 < 8) cur = {cur[6:0], sda_line};
                else begin cap_byte = cur; cap_ack = sda_line; n_cap++; end
                rises++;
                period = cyc - last_rise;
                last_rise = cyc;
            end
            if (prev_scl && !scl_line) nb = rises % 9;
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    int total = 0, bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic wait_pend(input string req);
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(5'h00, v);
            if (v[4]) return;
        end
        chk(req, 0, 1);
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(5'h04, v);
            if (!v[5]) return;
        end
        chk(req, 1, 0);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(5'h00, v); chk("R1 ctrl", v, 8'h00);
        rd(5'h04, v); chk("R1 stat", v, 8'h00);
        rd(5'h0C, v); chk("R1 data", v, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 lines", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_address;
        logic [7:0] v;
        slave_tx = 1'b0; slave_ack = 1'b1;
        wr(5'h0C, 8'hA4);
        wr(5'h00, 8'hA0);
        wr(5'h04, 8'hF0);
        rd(5'h04, v); chk("R2 busy", v[5], 1);
        wait_pend("R4 pend timeout");
        chk("R2 start seen", n_start, 1);
        chk("R2 addr byte", cap_byte, 8'hA4);
        chk("R5 irq on", irq, 1);
        rd(5'h04, v); chk("R6 ack bit", v[0], 0);
        chk("R3 period fast d0", period, 16);
        repeat (300) @(negedge clk);
        chk("R4 scl held", scl_oe, 1);
        chk("R4 no extra byte", n_cap, 1);
    endtask

    task automatic t_write_nack;
        logic [7:0] v;
        slave_ack = 1'b0;
        wr(5'h0C, 8'h5B);
        wr(5'h00, 8'h22);
        chk("R5 irq off", irq, 0);
        wait_pend("R4 pend timeout");
        chk("R6 data byte", cap_byte, 8'h5B);
        rd(5'h04, v); chk("R6 nack bit", v[0], 1);
        chk("R3 period fast d2", period, 48);
    endtask

    task automatic t_pend_one;
        logic [7:0] v;
        wr(5'h00, 8'hB0);
        repeat (60) @(negedge clk);
        rd(5'h00, v); chk("R4 pend kept", v[4], 1);
        chk("R4 scl still low", scl_oe, 1);
        chk("R4 no byte", n_cap, 2);
    endtask

    task automatic t_read_ack;
        logic [7:0] v;
        wr(5'h04, 8'hB0);
        slave_tx = 1'b1; slave_byte = 8'h3C;
        wr(5'h00, 8'hA0);
        repeat (20) @(negedge clk);
        rd(5'h0C, v); chk("R7 old data", v, 8'h5B);
        wait_pend("R4 pend timeout");
        chk("R2 no restart", n_start, 1);
        rd(5'h0C, v); chk("R7 rx byte", v, 8'h3C);
        chk("R8 ack driven", cap_ack, 0);
    endtask

    task automatic t_read_nack;
        logic [7:0] v;
        wr(5'h00, 8'h30);
        slave_byte = 8'hC3;
        wr(5'h00, 8'h20);
        wait_pend("R4 pend timeout");
        rd(5'h0C, v); chk("R7 rx last", v, 8'hC3);
        chk("R8 nack", cap_ack, 1);
    endtask

    task automatic t_stop;
        logic [7:0] v;
        slave_tx = 1'b0;
        wr(5'h04, 8'h90);
        rd(5'h04, v); chk("R9 busy until stop", v[5], 1);
        wr(5'h00, 8'h20);
        wait_idle("R9 idle timeout");
        chk("R9 stop seen", n_stop, 1);
        chk("R9 lines free", {scl_oe, sda_oe}, 0);
        chk("R9 no byte", n_cap, 4);
    endtask

    task automatic t_slow_noirq;
        slave_ack = 1'b1;
        wr(5'h00, 8'h40);
        wr(5'h0C, 8'h81);
        wr(5'h04, 8'hF0);
        wait_pend("R4 pend timeout");
        chk("R5 irq masked", irq, 0);
        chk("R3 period slow", period, 512);
        chk("R6 byte slow", cap_byte, 8'h81);
        wr(5'h04, 8'hD0);
        wr(5'h00, 8'h40);
        wait_idle("R9 idle timeout");
        chk("R9 second stop", n_stop, 2);
    endtask

    task automatic t_ignored_start;
        logic [7:0] v;
        wr(5'h04, 8'h30);
        repeat (100) @(negedge clk);
        rd(5'h04, v); chk("R2 slave mode idle", v[5], 0);
        wr(5'h04, 8'hE0);
        repeat (100) @(negedge clk);
        rd(5'h04, v); chk("R2 txen off idle", v[5], 0);
        chk("R2 no start", n_start, 2);
        chk("R2 scl free", scl_oe, 0);
    endtask

    task automatic t_stubs;
        logic [7:0] v;
        wr(5'h08, 8'h55);
        rd(5'h08, v); chk("R11 own addr", v, 8'h55);
        wr(5'h10, 8'hFF);
        rd(5'h10, v); chk("R11 line ctl", v, 8'h07);
        wr(5'h04, 8'h0E);
        rd(5'h04, v); chk("R11 stub flags", v & 8'h0E, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_address();
        t_write_nack();
        t_pend_one();
        t_read_ack();
        t_read_nack();
        t_stop();
        t_slow_noirq();
        t_ignored_start();
        t_stubs();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule